// File: doc/BRIEF.md
# Overlapped Register-Window File

This block is a register file in which a procedure sees 32 logical registers while the storage behind them is shared between several windows arranged in a ring. Ten logical registers are global and always reach the same storage. The other 22 are split into six incoming-argument registers, ten private registers and six outgoing-argument registers. The outgoing group of one window is the same storage as the incoming group of the next window, so a caller passes arguments and receives results without copying anything.

A window pointer chooses the active window. A call strobe advances it by one and a return strobe moves it back by one, wrapping around the ring. A depth counter records how many windows are in use. A call that would need more windows than exist raises an overflow trap. A return with no window to go back to raises an underflow trap. In both trap cases the pointer does not move. Two combinational read ports and one write port, taken on the clock edge, all work through the active window.

Top module: `rwin_file`

## Requirements
- R1: Logical registers 1 to 9 reach the same storage in every window. A value written to one of them is read back unchanged after any number of calls and returns.
- R2: Logical register 0 always reads as zero on both read ports. A write to it has no effect.
- R3: In window w, logical registers 26 to 31 are the same storage as logical registers 10 to 15 of window (w+1) mod 4. This includes the wrap from window 3 back to window 0. The rule holds in both directions.
- R4: Logical registers 16 to 25 are private to each window. Writing them in one window leaves the same numbers in every other window unchanged.
- R5: A call strobe alone, with depth below 3, increments `cwp_o` modulo 4 after the clock edge. A return strobe alone, with depth above 0, decrements it.
- R6: A call strobe alone at depth 3 drives `trap_ovf_o` high in that same cycle, and `cwp_o` stays as it was.
- R7: A return strobe alone at depth 0 drives `trap_unf_o` high in that same cycle, and `cwp_o` stays as it was.
- R8: Call and return strobes in the same cycle cancel. No trap is raised, and neither the pointer nor the depth changes.
- R9: After synchronous reset, `cwp_o` is 0, the depth is 0, both traps are low and every register reads zero.
- R10: Reads are combinational. A write becomes visible only after the clock edge. A write in the same cycle as a call strobe goes into the window that was active before the call.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 5 | Logical register number, read port A |
| rd_a_data | output | DATA_W | Read data, port A (combinational) |
| rd_b_addr | input | 5 | Logical register number, read port B |
| rd_b_data | output | DATA_W | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number for the write |
| wr_data | input | DATA_W | Write data |
| call_i | input | 1 | Call strobe: move to the next window |
| ret_i | input | 1 | Return strobe: move to the previous window |
| cwp_o | output | 2 | Current window pointer |
| trap_ovf_o | output | 1 | Window overflow, same cycle as the offending call |
| trap_unf_o | output | 1 | Window underflow, same cycle as the offending return |

## Verification
The assertions check the pointer on every cycle. Each untrapped call or return moves it by one step, a trapping strobe or a cancelled pair leaves it where it was, and logical register 0 reads as zero on both ports. Whether data lands in the right storage only shows up in the bench's scenarios. Those scenarios cover argument registers aliasing between neighbouring windows across the 3-to-0 wrap, private registers staying separate, globals surviving window moves, and a write made together with a call landing in the caller's window.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    // Window geometry. N_WIN must be a power of two (pointer wraps naturally).
    localparam int unsigned N_GLOB     = 10;
    localparam int unsigned N_LOC      = 10;
    localparam int unsigned N_COM      = 6;
    localparam int unsigned N_WIN      = 4;
    localparam int unsigned WIN_STRIDE = N_LOC + N_COM;
    localparam int unsigned RING       = WIN_STRIDE * N_WIN;
    localparam int unsigned N_PHYS     = N_GLOB + RING;
    localparam int unsigned N_LOGICAL  = N_GLOB + N_LOC + 2 * N_COM;
    localparam int unsigned LREG_W     = $clog2(N_LOGICAL);
    localparam int unsigned PREG_W     = $clog2(N_PHYS);
    localparam int unsigned CWP_W      = $clog2(N_WIN);

    typedef logic [LREG_W-1:0] lreg_t;
    typedef logic [PREG_W-1:0] preg_t;
    typedef logic [CWP_W-1:0]  cwp_t;

    typedef enum logic [1:0] {
        WIN_HOLD = 2'd0,
        WIN_CALL = 2'd1,
        WIN_RET  = 2'd2
    } win_op_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } win_trap_t;

    // Logical-to-physical translation: globals pass through, the rest
    // rotate around a ring offset by one window stride per pointer step.
    function automatic preg_t map_reg(input cwp_t w, input lreg_t n);
        int unsigned wu;
        int unsigned nu;
        int unsigned idx;
        wu = 32'(w);
        nu = 32'(n);
        if (nu < N_GLOB) begin
            idx = nu;
        end else begin
            idx = N_GLOB + ((wu * WIN_STRIDE + nu - N_GLOB) % RING);
        end
        return preg_t'(idx);
    endfunction

endpackage

// File: rtl/rwin_xlate.sv
module rwin_xlate
    import rwin_pkg::*;
(
    input  cwp_t  cwp,
    input  lreg_t lreg,
    output preg_t preg
);

    always_comb begin
        preg = map_reg(cwp, lreg);
    end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      call_i,
    input  logic      ret_i,
    output cwp_t      cwp,
    output win_trap_t trap
);

    cwp_t    depth;
    win_op_e op;

    always_comb begin
        if (call_i && !ret_i)      op = WIN_CALL;
        else if (ret_i && !call_i) op = WIN_RET;
        else                       op = WIN_HOLD;
    end

    always_comb begin
        trap.ovf = (op == WIN_CALL) && (depth == cwp_t'(N_WIN - 1));
        trap.unf = (op == WIN_RET)  && (depth == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp   <= '0;
            depth <= '0;
        end else begin
            unique case (op)
                WIN_CALL: if (!trap.ovf) begin
                    cwp   <= cwp + 1'b1;
                    depth <= depth + 1'b1;
                end
                WIN_RET: if (!trap.unf) begin
                    cwp   <= cwp - 1'b1;
                    depth <= depth - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_call_step_R5: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i && !trap.ovf) |=> (cwp == $past(cwp) + 1'b1));

    assert_ret_step_R5: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && !trap.unf) |=> (cwp == $past(cwp) - 1'b1));

    assert_ovf_hold_R6: assert property (@(posedge clk) disable iff (rst)
        trap.ovf |=> $stable(cwp));

    assert_unf_hold_R7: assert property (@(posedge clk) disable iff (rst)
        trap.unf |=> $stable(cwp));

    assert_pair_cancel_R8: assert property (@(posedge clk) disable iff (rst)
        (call_i && ret_i) |=> $stable(cwp));

endmodule

// File: rtl/rwin_store.sv
module rwin_store
    import rwin_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  preg_t             w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  preg_t             ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  preg_t             rb_idx,
    output logic [DATA_W-1:0] rb_data
);

    logic [DATA_W-1:0] cells [N_PHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(N_PHYS); i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[w_idx] <= w_data;
        end
    end

    always_comb begin
        ra_data = cells[ra_idx];
        rb_data = cells[rb_idx];
    end

endmodule

// File: rtl/rwin_file.sv
module rwin_file
    import rwin_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [4:0]        rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              call_i,
    input  logic              ret_i,
    output logic [1:0]        cwp_o,
    output logic              trap_ovf_o,
    output logic              trap_unf_o
);

    localparam int unsigned N_PORT = 3;  // read A, read B, write

    cwp_t              cwp;
    win_trap_t         trap;
    lreg_t             port_l [N_PORT];
    preg_t             port_p [N_PORT];
    logic [DATA_W-1:0] raw_a;
    logic [DATA_W-1:0] raw_b;
    logic              wr_go;

    rwin_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .call_i (call_i),
        .ret_i  (ret_i),
        .cwp    (cwp),
        .trap   (trap)
    );

    always_comb begin
        port_l[0] = lreg_t'(rd_a_addr);
        port_l[1] = lreg_t'(rd_b_addr);
        port_l[2] = lreg_t'(wr_addr);
    end

    for (genvar p = 0; p < N_PORT; p++) begin : g_xlate
        rwin_xlate u_xlate (
            .cwp  (cwp),
            .lreg (port_l[p]),
            .preg (port_p[p])
        );
    end

    assign wr_go = wr_en && (wr_addr != '0);

    rwin_store #(.DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_go),
        .w_idx   (port_p[2]),
        .w_data  (wr_data),
        .ra_idx  (port_p[0]),
        .ra_data (raw_a),
        .rb_idx  (port_p[1]),
        .rb_data (raw_b)
    );

    assign rd_a_data  = (rd_a_addr == '0) ? '0 : raw_a;
    assign rd_b_data  = (rd_b_addr == '0) ? '0 : raw_b;
    assign cwp_o      = 2'(cwp);
    assign trap_ovf_o = trap.ovf;
    assign trap_unf_o = trap.unf;

    assert_zero_read_a_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == '0) |-> (rd_a_data == '0));

    assert_zero_read_b_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == '0) |-> (rd_b_data == '0));

endmodule

// File: tb/rwin_file_tb.sv
module rwin_file_tb;

    localparam int DW = 16;
    localparam int NV = 26;
    // op: 0 write, 1 read-check, 2 call (exp = cwp), 3 return (exp = cwp)
    localparam logic [38:0] VEC [NV] = '{
        {2'd0, 5'd5,  16'h1111, 16'h0000},
        {2'd0, 5'd26, 16'h2626, 16'h0000},
        {2'd0, 5'd16, 16'h0016, 16'h0000},
        {2'd2, 5'd0,  16'h0000, 16'h0001},
        {2'd1, 5'd5,  16'h0000, 16'h1111},  // R1
        {2'd1, 5'd10, 16'h0000, 16'h2626},  // R3
        {2'd1, 5'd16, 16'h0000, 16'h0000},  // R4
        {2'd0, 5'd16, 16'hB016, 16'h0000},
        {2'd0, 5'd10, 16'hA0A0, 16'h0000},
        {2'd0, 5'd26, 16'h3131, 16'h0000},
        {2'd2, 5'd0,  16'h0000, 16'h0002},
        {2'd1, 5'd10, 16'h0000, 16'h3131},  // R3
        {2'd0, 5'd26, 16'h4242, 16'h0000},
        {2'd2, 5'd0,  16'h0000, 16'h0003},
        {2'd1, 5'd10, 16'h0000, 16'h4242},  // R3
        {2'd0, 5'd26, 16'h5050, 16'h0000},
        {2'd0, 5'd0,  16'hFFFF, 16'h0000},
        {2'd1, 5'd0,  16'h0000, 16'h0000},  // R2
        {2'd3, 5'd0,  16'h0000, 16'h0002},
        {2'd3, 5'd0,  16'h0000, 16'h0001},
        {2'd1, 5'd16, 16'h0000, 16'hB016},  // R4
        {2'd3, 5'd0,  16'h0000, 16'h0000},
        {2'd1, 5'd26, 16'h0000, 16'hA0A0},  // R3 result back
        {2'd1, 5'd16, 16'h0000, 16'h0016},  // R4
        {2'd1, 5'd10, 16'h0000, 16'h5050},  // R3 wrap 3->0
        {2'd1, 5'd5,  16'h0000, 16'h1111}   // R1
    };

    logic          clk = 0;
    logic          rst = 1;
    logic [4:0]    rd_a_addr = '0;
    logic [4:0]    rd_b_addr = '0;
    logic [DW-1:0] rd_a_data;
    logic [DW-1:0] rd_b_data;
    logic          wr_en = 0;
    logic [4:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          call_i = 0;
    logic          ret_i = 0;
    logic [1:0]    cwp_o;
    logic          trap_ovf_o;
    logic          trap_unf_o;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 0;

    always #4 clk = ~clk;  // 125 MHz

    rwin_file #(.DATA_W(DW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .rd_a_addr  (rd_a_addr),
        .rd_a_data  (rd_a_data),
        .rd_b_addr  (rd_b_addr),
        .rd_b_data  (rd_b_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .call_i     (call_i),
        .ret_i      (ret_i),
        .cwp_o      (cwp_o),
        .trap_ovf_o (trap_ovf_o),
        .trap_unf_o (trap_unf_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [4:0] a, input logic [DW-1:0] exp, input string req);
        rd_a_addr = a;
        rd_b_addr = a;
        #1;
        check(req, {16'h0, rd_a_data}, {16'h0, exp});
        check(req, {16'h0, rd_b_data}, {16'h0, exp});
    endtask

    task automatic do_call(input logic [1:0] exp_cwp, input string req);
        call_i = 1;
        step();
        call_i = 0;
        check(req, 32'(cwp_o), 32'(exp_cwp));
    endtask

    task automatic do_ret(input logic [1:0] exp_cwp, input string req);
        ret_i = 1;
        step();
        ret_i = 0;
        check(req, 32'(cwp_o), 32'(exp_cwp));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst = 0;
        #1;
        // R9: reset state
        check("R9 cwp", 32'(cwp_o), 32'd0);
        check("R9 traps", {30'd0, trap_ovf_o, trap_unf_o}, 32'd0);
        rd(5'd5, 16'h0, "R9 global");
        rd(5'd26, 16'h0, "R9 windowed");

        for (int i = 0; i < NV; i++) begin
            logic [1:0]    op;
            logic [4:0]    ad;
            logic [DW-1:0] dt;
            logic [DW-1:0] ex;
            {op, ad, dt, ex} = VEC[i];
            case (op)
                2'd0: begin
                    wr_en = 1; wr_addr = ad; wr_data = dt;
                    step();
                    wr_en = 0;
                end
                2'd1: rd(ad, ex, "R1/R2/R3/R4 table read");
                2'd2: do_call(ex[1:0], "R5 call");
                default: do_ret(ex[1:0], "R5 return");
            endcase
        end

        // R7: underflow at depth 0
        ret_i = 1;
        #1;
        check("R7 unf", 32'(trap_unf_o), 32'd1);
        check("R7 no ovf", 32'(trap_ovf_o), 32'd0);
        step();
        ret_i = 0;
        check("R7 cwp held", 32'(cwp_o), 32'd0);

        // R8: simultaneous strobes cancel
        call_i = 1; ret_i = 1;
        #1;
        check("R8 no trap", {30'd0, trap_ovf_o, trap_unf_o}, 32'd0);
        step();
        call_i = 0; ret_i = 0;
        check("R8 cwp held", 32'(cwp_o), 32'd0);
        ret_i = 1;
        #1;
        check("R8 depth held", 32'(trap_unf_o), 32'd1);
        step();
        ret_i = 0;

        // R6: overflow at depth 3
        do_call(2'd1, "R5 call");
        do_call(2'd2, "R5 call");
        do_call(2'd3, "R5 call");
        call_i = 1;
        #1;
        check("R6 ovf", 32'(trap_ovf_o), 32'd1);
        step();
        call_i = 0;
        check("R6 cwp held", 32'(cwp_o), 32'd3);
        do_ret(2'd2, "R6 depth held");
        do_ret(2'd1, "R5 return");
        do_ret(2'd0, "R5 return");

        // R10: combinational read, write visible after edge
        wr_en = 1; wr_addr = 5'd20; wr_data = 16'h1234;
        rd(5'd20, 16'h0000, "R10 before edge");
        step();
        wr_en = 0;
        rd(5'd20, 16'h1234, "R10 after edge");

        // R10: write with call goes to the caller's window
        wr_en = 1; wr_addr = 5'd17; wr_data = 16'h7777; call_i = 1;
        step();
        wr_en = 0; call_i = 0;
        check("R10 cwp", 32'(cwp_o), 32'd1);
        rd(5'd17, 16'h0000, "R10 callee untouched");
        do_ret(2'd0, "R5 return");
        rd(5'd17, 16'h7777, "R10 caller written");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule